// File: doc/BRIEF.md
# Tagged-Data Usage Checker

This unit decides, instruction by instruction, whether tagged (untrusted) data is being used in a forbidden way. The surrounding pipeline presents one instruction per cycle: an instruction class and four tag bits. The tags flag a tagged source operand, a tagged result, a tagged address operand (the jump or branch target, or the load/store address register) and a tagged value about to be written into the program counter. The rules that apply are set by software in a 22-bit check policy register. There is one 3-bit rule field per instruction class and one extra bit for the program-counter rule.

When an enabled rule matches, the unit asserts a same-cycle block signal that suppresses the faulting fetch or memory access. One cycle later it raises a one-cycle security exception. It also records the class and operand role of the fault in a sticky cause register, which holds until software clears it. Tagged data that is only computed on raises nothing unless a data-role rule is armed for that class. A policy of all zeros turns every check off.

Top module: `tag_check_unit`

## Requirements
- R1: After reset the policy reads 0, the cause is not valid, and both the security exception and the block signal are low.
- R2: A write strobe loads the 22-bit policy at the clock edge, and the read port returns it from the next cycle on. Checks in the cycle of the write still use the old policy.
- R3: With a policy of all zeros, no combination of class and tags raises the block signal or the exception.
- R4: Policy bit 0 enables the program-counter rule: a valid instruction whose program-counter tag is set violates, whatever its class. Its cause role is 3.
- R5: Class codes are 0 arithmetic, 1 branch, 2 jump, 3 shift, 4 logical, 5 comparison and 6 load/store. Class c uses policy bits [3c+3:3c+1]. Within that field, bit 0 checks the source-data tag (role 0), bit 1 the destination-data tag (role 1) and bit 2 the address tag (role 2). Fields of other classes have no effect.
- R6: Class code 7, or an instruction with the valid bit low, never violates a class rule. An invalid instruction never violates at all.
- R7: The block signal is high in the same cycle as a violating instruction and low otherwise.
- R8: The security exception is high for exactly the one cycle after each violating instruction, and low after non-violating ones.
- R9: On a violation while the cause is not valid, the cause latches the class and the role of highest priority, in the order program counter, address, destination data, source data. A later violation does not overwrite a valid cause.
- R10: A clear strobe invalidates the cause at the next edge. If a violation arrives in the same cycle as the clear, the new fault is latched instead.
- R11: With only the address and program-counter rules armed, set source or destination data tags never raise the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Policy write strobe |
| cfgWrData | input | 22 | Policy write value |
| cfgRdData | output | 22 | Current policy |
| causeClr | input | 1 | Clear the sticky cause |
| instValid | input | 1 | An instruction is presented this cycle |
| instClass | input | 3 | Instruction class code |
| tagSrcData | input | 1 | Tag of the source data operand |
| tagDstData | input | 1 | Tag of the result data |
| tagAddr | input | 1 | Tag of the address operand (branch/jump target or load/store address) |
| tagPcTarget | input | 1 | Tag of the value entering the program counter |
| blockAccess | output | 1 | Suppress the current fetch or memory access |
| secExc | output | 1 | One-cycle security exception |
| causeValid | output | 1 | The cause register holds a fault |
| causeClass | output | 3 | Class of the recorded fault |
| causeRole | output | 2 | Role of the recorded fault |

## Verification
Several cases are hard to reach from the ports. One is a clear strobe arriving in the same cycle as a fresh violation. Another is a second fault hitting an already valid cause. A third is a policy write landing in the same cycle as a check. The stimulus builds each of these on purpose: it arms one rule, fires one fault, then pairs a clear with a second fault of a different class and role. A sweep then arms each class field bit by bit and presents fully tagged instructions, first of the matching class and then of a neighbouring class. This exposes any off-by-one field placement. A long random run with occasional policy writes and clears compares every output on every cycle against a behavioural model.

// File: rtl/tag_check_pkg.sv
package tag_check_pkg;
  parameter int CLASS_W   = 3;
  parameter int NUM_CLASS = 7;
  parameter int FIELD_W   = 3;
  parameter int POLICY_W  = 1 + NUM_CLASS * FIELD_W;

  typedef enum logic [1:0] {
    ROLE_SRC_DATA = 2'd0,
    ROLE_DST_DATA = 2'd1,
    ROLE_ADDR     = 2'd2,
    ROLE_PC       = 2'd3
  } role_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } chk_strobe_t;
endpackage

// File: rtl/tag_check_datapath.sv
module tag_check_datapath
  import tag_check_pkg::*;
#(
  parameter int ClassW   = CLASS_W,
  parameter int NumClass = NUM_CLASS,
  parameter int FieldW   = FIELD_W,
  localparam int PolicyW = 1 + NumClass * FieldW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [PolicyW-1:0] cfgWrData,
  output logic [PolicyW-1:0] policyQ,
  input  logic               instValid,
  input  logic [ClassW-1:0]  instClass,
  input  logic               tagSrcData,
  input  logic               tagDstData,
  input  logic               tagAddr,
  input  logic               tagPcTarget,
  input  chk_strobe_t        strobe,
  output logic               violation,
  output logic               causeValid,
  output logic [ClassW-1:0]  causeClass,
  output logic [1:0]         causeRole
);
  logic [FieldW-1:0] fieldArr [NumClass];
  logic [FieldW-1:0] selField;
  logic              hitSrc, hitDst, hitAddr, hitPc;
  role_e             hitRole;

  always_ff @(posedge clk) begin
    if (!rstN) policyQ <= '0;
    else if (cfgWrEn) policyQ <= cfgWrData;
  end

  for (genvar c = 0; c < NumClass; c++) begin : g_field
    assign fieldArr[c] = policyQ[1 + c*FieldW +: FieldW];
  end

  always_comb begin
    selField = '0;
    for (int c = 0; c < NumClass; c++) begin
      if (int'(instClass) == c) selField = fieldArr[c];
    end
  end

  assign hitSrc  = instValid & selField[0] & tagSrcData;
  assign hitDst  = instValid & selField[1] & tagDstData;
  assign hitAddr = instValid & selField[2] & tagAddr;
  assign hitPc   = instValid & policyQ[0] & tagPcTarget;
  assign violation = hitSrc | hitDst | hitAddr | hitPc;

  always_comb begin
    if (hitPc)        hitRole = ROLE_PC;
    else if (hitAddr) hitRole = ROLE_ADDR;
    else if (hitDst)  hitRole = ROLE_DST_DATA;
    else              hitRole = ROLE_SRC_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeValid <= 1'b0;
      causeClass <= '0;
      causeRole  <= '0;
    end else if (strobe.capture) begin
      causeValid <= 1'b1;
      causeClass <= instClass;
      causeRole  <= hitRole;
    end else if (strobe.clear) begin
      causeValid <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_check_control.sv
module tag_check_control
  import tag_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        violation,
  input  logic        causeValid,
  input  logic        causeClr,
  output chk_strobe_t strobe,
  output logic        blockAccess,
  output logic        secExc
);
  always_comb begin
    strobe.capture = violation & (~causeValid | causeClr);
    strobe.clear   = causeClr;
  end

  assign blockAccess = violation;

  always_ff @(posedge clk) begin
    if (!rstN) secExc <= 1'b0;
    else       secExc <= violation;
  end
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tag_check_pkg::*;
#(
  parameter int ClassW   = CLASS_W,
  parameter int NumClass = NUM_CLASS,
  parameter int FieldW   = FIELD_W,
  localparam int PolicyW = 1 + NumClass * FieldW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [PolicyW-1:0] cfgWrData,
  output logic [PolicyW-1:0] cfgRdData,
  input  logic               causeClr,
  input  logic               instValid,
  input  logic [ClassW-1:0]  instClass,
  input  logic               tagSrcData,
  input  logic               tagDstData,
  input  logic               tagAddr,
  input  logic               tagPcTarget,
  output logic               blockAccess,
  output logic               secExc,
  output logic               causeValid,
  output logic [ClassW-1:0]  causeClass,
  output logic [1:0]         causeRole
);
  chk_strobe_t strobe;
  logic        violation;

  tag_check_datapath #(
    .ClassW(ClassW), .NumClass(NumClass), .FieldW(FieldW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .policyQ(cfgRdData),
    .instValid(instValid), .instClass(instClass),
    .tagSrcData(tagSrcData), .tagDstData(tagDstData),
    .tagAddr(tagAddr), .tagPcTarget(tagPcTarget),
    .strobe(strobe), .violation(violation),
    .causeValid(causeValid), .causeClass(causeClass), .causeRole(causeRole)
  );

  tag_check_control u_ctl (
    .clk(clk), .rstN(rstN),
    .violation(violation), .causeValid(causeValid), .causeClr(causeClr),
    .strobe(strobe), .blockAccess(blockAccess), .secExc(secExc)
  );
endmodule

// File: rtl/tag_check_sva.sv
module tag_check_sva #(
  parameter int ClassW  = 3,
  parameter int PolicyW = 22
) (
  input logic               clk,
  input logic               rstN,
  input logic [PolicyW-1:0] cfgRdData,
  input logic               causeClr,
  input logic               instValid,
  input logic               tagPcTarget,
  input logic               blockAccess,
  input logic               secExc,
  input logic               causeValid,
  input logic [ClassW-1:0]  causeClass,
  input logic [1:0]         causeRole
);
  AST_ZERO_POLICY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData == '0) |-> !blockAccess); // R3
  AST_PC_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && cfgRdData[0] && tagPcTarget) |-> blockAccess); // R4
  AST_IDLE_NO_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !blockAccess); // R6
  AST_EXC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    blockAccess |=> secExc); // R8
  AST_EXC_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    !blockAccess |=> !secExc); // R8
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (causeValid && !causeClr) |=> (causeValid && $stable(causeClass) && $stable(causeRole))); // R9
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rstN)
    blockAccess |=> causeValid); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (causeClr && !blockAccess) |=> !causeValid); // R10
endmodule

bind tag_check_unit tag_check_sva #(.ClassW(ClassW), .PolicyW(PolicyW)) u_sva (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .causeClr(causeClr),
  .instValid(instValid), .tagPcTarget(tagPcTarget), .blockAccess(blockAccess),
  .secExc(secExc), .causeValid(causeValid), .causeClass(causeClass),
  .causeRole(causeRole)
);

// File: tb/sim_tag_check_unit.sv
`timescale 1ns/1ps
module sim_tag_check_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [21:0] cfgWrData = '0;
  logic [21:0] cfgRdData;
  logic        causeClr = 1'b0;
  logic        instValid = 1'b0;
  logic [2:0]  instClass = '0;
  logic        tagSrcData = 1'b0, tagDstData = 1'b0, tagAddr = 1'b0, tagPcTarget = 1'b0;
  logic        blockAccess, secExc, causeValid;
  logic [2:0]  causeClass;
  logic [1:0]  causeRole;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [21:0] mPol = '0;
  bit          mExc = 0;
  bit          mCv = 0;
  int          mCls = 0;
  int          mRole = 0;

  always #2 clk = ~clk;

  tag_check_unit u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .causeClr(causeClr), .instValid(instValid),
    .instClass(instClass), .tagSrcData(tagSrcData), .tagDstData(tagDstData),
    .tagAddr(tagAddr), .tagPcTarget(tagPcTarget), .blockAccess(blockAccess),
    .secExc(secExc), .causeValid(causeValid), .causeClass(causeClass),
    .causeRole(causeRole)
  );

  // returns -1 for no violation, else the role code
  function automatic int refRole(logic [21:0] pol, bit v, int cls, bit s, bit d, bit a, bit p);
    bit fs = 0, fd = 0, fa = 0;
    if (!v) return -1;
    if (cls < 7) begin
      fs = pol[3*cls+1]; fd = pol[3*cls+2]; fa = pol[3*cls+3];
    end
    if (pol[0] && p) return 3;
    if (fa && a) return 2;
    if (fd && d) return 1;
    if (fs && s) return 0;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational output, clock, check registers
  task automatic step(bit v, int cls, bit s, bit d, bit a, bit p,
                      bit clr, bit wr, logic [21:0] wd, string req);
    int r;
    @(negedge clk);
    instValid = v; instClass = cls[2:0];
    tagSrcData = s; tagDstData = d; tagAddr = a; tagPcTarget = p;
    causeClr = clr; cfgWrEn = wr; cfgWrData = wd;
    #1;
    r = refRole(mPol, v, cls, s, d, a, p);
    check(blockAccess == (r >= 0), req, "blockAccess", int'(blockAccess), int'(r >= 0));
    @(posedge clk);
    mExc = (r >= 0);
    if (r >= 0 && (!mCv || clr)) begin
      mCv = 1; mCls = cls; mRole = r;
    end else if (clr) mCv = 0;
    if (wr) mPol = wd;
    #1;
    check(secExc == mExc, "R8", "secExc", int'(secExc), int'(mExc));
    check(causeValid == mCv, "R9", "causeValid", int'(causeValid), int'(mCv));
    if (mCv) begin
      check(int'(causeClass) == mCls, "R9", "causeClass", int'(causeClass), mCls);
      check(int'(causeRole) == mRole, "R9", "causeRole", int'(causeRole), mRole);
    end
    check(cfgRdData == mPol, "R2", "cfgRdData", int'(cfgRdData), int'(mPol));
  endtask

  task automatic setPol(logic [21:0] p);
    step(0, 0, 0, 0, 0, 0, 1, 1, p, "R2");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    check(cfgRdData == 0, "R1", "cfgRdData", int'(cfgRdData), 0);
    check(!causeValid, "R1", "causeValid", int'(causeValid), 0);
    check(!secExc && !blockAccess, "R1", "secExc|blockAccess", int'(secExc | blockAccess), 0);

    // R3 zero policy: every class, all tags
    for (int c = 0; c < 8; c++) step(1, c, 1, 1, 1, 1, 0, 0, '0, "R3");

    // R2 write/readback, and write-cycle uses old policy
    step(1, 6, 1, 1, 1, 1, 0, 1, 22'h3FFFFF, "R2");
    step(1, 6, 1, 1, 1, 1, 1, 0, '0, "R2");
    setPol('0);

    // R4 program-counter rule regardless of class
    setPol(22'h000001);
    for (int c = 0; c < 8; c++) begin
      step(1, c, 0, 0, 0, 1, 0, 0, '0, "R4");
      step(1, c, 1, 1, 1, 0, 1, 0, '0, "R4");
    end

    // R5 field mapping sweep
    for (int c = 0; c < 7; c++) begin
      for (int b = 0; b < 3; b++) begin
        setPol(22'(1) << (3*c + 1 + b));
        step(1, c, 1, 1, 1, 1, 0, 0, '0, "R5");
        step(1, (c + 1) % 8, 1, 1, 1, 1, 1, 0, '0, "R5");
        step(1, c, b == 0, b == 1, b == 2, 0, 1, 0, '0, "R5");
        step(1, c, b != 0, b != 1, b != 2, 0, 1, 0, '0, "R5");
      end
    end

    // R6 class 7 and invalid instructions
    setPol(22'h3FFFFE);
    step(1, 7, 1, 1, 1, 0, 0, 0, '0, "R6");
    step(0, 6, 1, 1, 1, 1, 0, 0, '0, "R6");

    // R7 same-cycle block
    step(1, 6, 0, 0, 1, 0, 1, 0, '0, "R7");
    step(1, 6, 0, 0, 0, 0, 1, 0, '0, "R7");

    // R9 priority and first-fault retention
    setPol(22'h3FFFFF);
    step(1, 2, 1, 1, 1, 1, 0, 0, '0, "R9");
    step(1, 0, 1, 0, 0, 0, 0, 0, '0, "R9");
    check(causeRole == 2'd3 && causeClass == 3'd2, "R9", "retained cause", {causeClass, causeRole}, {3'd2, 2'd3});

    // R10 clear with simultaneous violation, then plain clear
    step(1, 4, 1, 1, 0, 0, 1, 0, '0, "R10");
    check(causeClass == 3'd4 && causeRole == 2'd1, "R10", "recaptured cause", {causeClass, causeRole}, {3'd4, 2'd1});
    step(0, 0, 0, 0, 0, 0, 1, 0, '0, "R10");
    check(!causeValid, "R10", "causeValid after clear", int'(causeValid), 0);

    // R11 address/PC rules only: data tags are harmless
    setPol(22'h249249);
    for (int c = 0; c < 8; c++) step(1, c, 1, 1, 0, 0, 0, 0, '0, "R11");

    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      bit wr = ($urandom % 40) == 0;
      step(($urandom % 4) != 0, int'($urandom % 8), 1'($urandom), 1'($urandom),
           1'($urandom), (($urandom % 4) == 0), (($urandom % 10) == 0),
           wr, 22'($urandom), "R5");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule